// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block merges a set of asynchronous interrupt request lines into a single request toward a processor core. Every line first passes through a two-flop synchronizer. After that, each source acts in one of two ways. In level mode it requests service while its input sits at the active level. In edge mode it sets a sticky pending bit on the active edge. A per-source polarity bit picks active-high or rising for one setting, and active-low or falling for the other.

An enable mask decides which sources may interrupt. A build-time parameter fixes whether a set mask bit enables its source or disables it. An edge that arrives while its source is masked is not lost. It stays pending and appears as soon as the source is unmasked. Of all sources that are enabled and requesting, the one with the lowest index is reported as a binary identifier next to a valid flag.

The core clears edge requests in one of two ways: a write-one-to-clear through the register write port, or an acknowledge strobe that names a source. The same write port also loads the mask, trigger-mode and polarity registers.

Top module: `irq_gather`

## Requirements
- R1: After reset, irq_valid_o is 0 and irq_id_o is 0. Trigger-mode and polarity registers reset to 0. The mask resets to the value that disables every source, so a high input raises no request.
- R2: A change on a level-mode input reaches irq_valid_o on the second rising clock edge after the change, and not on the first.
- R3: A level-mode source requests only while its synchronized input is at the active level. It latches nothing, so its request drops when the input returns to the inactive level.
- R4: For an edge-mode source (trigger-mode bit = 1), the active edge sets a pending bit that is visible at the output on the third rising clock edge after the input change. The bit stays set after the input returns and holds until it is cleared.
- R5: Polarity register bit = 0 selects active-high level and rising edge. Bit = 1 selects active-low level and falling edge, and an edge in the opposite direction sets nothing.
- R6: An edge on a masked source is kept pending. It is reported as soon as the source is unmasked.
- R7: Several active edges on one line before its pending bit is cleared merge into a single request, and one clear removes it.
- R8: When several sources are enabled and requesting, irq_id_o gives the lowest index among them as an unsigned binary number. irq_valid_o is 1 exactly when at least one source is enabled and requesting.
- R9: Register select values are: 0 = mask, 1 = trigger mode, 2 = polarity, 3 = pending clear. Writing select 3 clears the pending bits where the data has a 1 and leaves bits written with 0 untouched.
- R10: ack_i with ack_id_i clears the pending bit of that edge-mode source. An acknowledge to a level-mode source does not change its request.
- R11: If a clear and a new active edge hit the same source in the same cycle, the pending bit stays set.
- R12: With MASK_SET_ENABLES = 1, a mask bit of 1 enables its source and the mask resets to all zeros. With MASK_SET_ENABLES = 0, a mask bit of 1 disables its source and the mask resets to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | N_SRC | Asynchronous interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 mask, 1 trigger mode, 2 polarity, 3 pending clear) |
| wr_data_i | input | N_SRC | Write data, one bit per source |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_id_i | input | ID_W | Source cleared by the acknowledge |
| irq_valid_o | output | 1 | At least one enabled source is requesting |
| irq_id_o | output | ID_W | Index of the winning source |

## Verification
The level path is driven with single transitions. The exact sampling cycles separate the two-stage synchronizer delay from a shorter or longer path, and dropping the input separates true level behaviour from a stray latch. Edge sources receive single pulses, repeated pulses, pulses of the wrong direction and pulses while masked. These show sticky capture, merging, polarity selection and the retention of masked events. Mixed level and edge sources requesting together, then cleared one at a time, check the fixed lowest-index priority. A clear timed onto the same cycle as a fresh edge separates set-wins from clear-wins, and a second instance built with the inverted mask sense checks the other mask polarity.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_MASK     = 2'd0,
        SEL_TRIGGER  = 2'd1,
        SEL_POLARITY = 2'd2,
        SEL_PEND_CLR = 2'd3
    } reg_sel_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] async_i,
    output logic [N_SRC-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][N_SRC-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stage[k] = st_q.stage[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC            = 8,
    parameter bit          MASK_SET_ENABLES = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] enable_o,
    output logic [N_SRC-1:0] mode_o,
    output logic [N_SRC-1:0] pol_o,
    output logic [N_SRC-1:0] w1c_o
);

    localparam logic [N_SRC-1:0] MASK_RST = MASK_SET_ENABLES ? '0 : '1;

    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic [N_SRC-1:0] mode;
        logic [N_SRC-1:0] pol;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    reg_sel_e   sel;

    assign sel = reg_sel_e'(wr_sel_i);

    always_comb begin
        st_d  = st_q;
        w1c_o = '0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_MASK:     st_d.mask = wr_data_i;
                SEL_TRIGGER:  st_d.mode = wr_data_i;
                SEL_POLARITY: st_d.pol  = wr_data_i;
                SEL_PEND_CLR: w1c_o     = wr_data_i;
                default:      st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mask <= MASK_RST;
            st_q.mode <= '0;
            st_q.pol  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (MASK_SET_ENABLES) begin : g_mask_enables
            assign enable_o = st_q.mask;
        end else begin : g_mask_disables
            assign enable_o = ~st_q.mask;
        end
    endgenerate

    assign mode_o = st_q.mode;
    assign pol_o  = st_q.pol;

    AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (sel == SEL_MASK)) |=> $stable(st_q.mask)); // R12

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] sync_i,
    input  logic [N_SRC-1:0] mode_i,
    input  logic [N_SRC-1:0] pol_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] req_o
);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } pend_state_t;

    pend_state_t      st_d, st_q;
    logic [N_SRC-1:0] rise, fall, edge_ev, lvl_act;

    always_comb begin
        rise    = sync_i & ~st_q.prev;
        fall    = ~sync_i & st_q.prev;
        edge_ev = mode_i & ((rise & ~pol_i) | (fall & pol_i));
        lvl_act = sync_i ^ pol_i;

        st_d      = st_q;
        st_d.prev = sync_i;
        st_d.pend = mode_i & ((st_q.pend & ~clr_i) | edge_ev);

        req_o = (mode_i & st_q.pend) | (~mode_i & lvl_act);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(st_q.pend & ~clr_i & mode_i)) |=>
        (($past(st_q.pend & ~clr_i & mode_i) & ~st_q.pend) == '0)); // R4

    AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr_i & edge_ev)) |=>
        ((st_q.pend & $past(clr_i & edge_ev)) == $past(clr_i & edge_ev))); // R11

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(~mode_i)) |=> ((st_q.pend & $past(~mode_i)) == '0)); // R3

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned ID_W  = 3
) (
    input  logic [N_SRC-1:0] active_i,
    output logic             valid_o,
    output logic [ID_W-1:0]  id_o
);

    always_comb begin
        valid_o = |active_i;
        id_o    = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                id_o = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC            = 8,
    parameter bit          MASK_SET_ENABLES = 1'b1,
    localparam int unsigned ID_W            = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] irq_lines_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic             ack_i,
    input  logic [ID_W-1:0]  ack_id_i,
    output logic             irq_valid_o,
    output logic [ID_W-1:0]  irq_id_o
);

    logic [N_SRC-1:0] sync_lines;
    logic [N_SRC-1:0] enable, mode, pol, w1c;
    logic [N_SRC-1:0] ack_vec, clr_vec;
    logic [N_SRC-1:0] req, active;

    irqc_sync #(
        .N_SRC (N_SRC),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(irq_lines_i),
        .sync_o (sync_lines)
    );

    irqc_cfg #(
        .N_SRC           (N_SRC),
        .MASK_SET_ENABLES(MASK_SET_ENABLES)
    ) i_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_data_i(wr_data_i),
        .enable_o (enable),
        .mode_o   (mode),
        .pol_o    (pol),
        .w1c_o    (w1c)
    );

    always_comb begin
        ack_vec = ack_i ? (N_SRC'(1) << ack_id_i) : '0;
        clr_vec = w1c | ack_vec;
    end

    irqc_pend #(
        .N_SRC(N_SRC)
    ) i_pend (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sync_i(sync_lines),
        .mode_i(mode),
        .pol_i (pol),
        .clr_i (clr_vec),
        .req_o (req)
    );

    assign active = req & enable;

    irqc_prio #(
        .N_SRC(N_SRC),
        .ID_W (ID_W)
    ) i_prio (
        .active_i(active),
        .valid_o (irq_valid_o),
        .id_o    (irq_id_o)
    );

    AST_WINNER_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> active[irq_id_o]); // R8

    AST_WINNER_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> ((active & ((N_SRC'(1) << irq_id_o) - N_SRC'(1))) == '0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active == '0) |-> !irq_valid_o); // R8

endmodule

// File: tb/test_irq_gather.sv
module test_irq_gather;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lines = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic [2:0] ack_id = '0;
    logic       irq_valid;
    logic [2:0] irq_id;

    logic [3:0] inv_lines = '0;
    logic       inv_wr_en = 1'b0;
    logic [3:0] inv_wr_data = '0;
    logic       inv_valid;
    logic [1:0] inv_id;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_gather i_irq_gather (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .irq_lines_i(lines),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .ack_i      (ack),
        .ack_id_i   (ack_id),
        .irq_valid_o(irq_valid),
        .irq_id_o   (irq_id)
    );

    irq_gather #(
        .N_SRC           (4),
        .MASK_SET_ENABLES(1'b0)
    ) i_irq_gather_inv (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .irq_lines_i(inv_lines),
        .wr_en_i    (inv_wr_en),
        .wr_sel_i   (2'd0),
        .wr_data_i  (inv_wr_data),
        .ack_i      (1'b0),
        .ack_id_i   (2'd0),
        .irq_valid_o(inv_valid),
        .irq_id_o   (inv_id)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input bit exp_v, input int exp_id);
        check(irq_valid === exp_v, {req, " valid"}, int'(irq_valid), int'(exp_v));
        if (exp_v) check(irq_id === 3'(exp_id), {req, " id"}, int'(irq_id), exp_id);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_ack(input int id);
        @(negedge clk);
        ack = 1'b1; ack_id = 3'(id);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        lines[k] = 1'b1;
        @(negedge clk);
        lines[k] = 1'b0;
    endtask

    task automatic t_reset();
        chk_out("R1 reset", 1'b0, 0);
        check(irq_id === 3'd0, "R1 reset id", int'(irq_id), 0);
        @(negedge clk); lines[0] = 1'b1;
        cycles(4);
        chk_out("R1 masked by reset", 1'b0, 0);
        @(negedge clk); lines[0] = 1'b0;
        cycles(3);
    endtask

    task automatic t_latency_level();
        wr_reg(2'd0, 8'h04);
        @(negedge clk); lines[2] = 1'b1;
        cycles(1);
        chk_out("R2 not after first edge", 1'b0, 0);
        cycles(1);
        chk_out("R2 after second edge", 1'b1, 2);
        @(negedge clk); lines[2] = 1'b0;
        cycles(3);
        chk_out("R3 level drops", 1'b0, 0);
        @(negedge clk); lines[2] = 1'b1;
        cycles(3);
        chk_out("R3 level again", 1'b1, 2);
        @(negedge clk); lines[2] = 1'b0;
        cycles(3);
    endtask

    task automatic t_edge();
        wr_reg(2'd1, 8'h08);
        wr_reg(2'd0, 8'h08);
        pulse(3);
        cycles(1);
        chk_out("R4 not yet pending", 1'b0, 0);
        cycles(1);
        chk_out("R4 pending", 1'b1, 3);
        cycles(5);
        chk_out("R4 sticky", 1'b1, 3);
        wr_reg(2'd3, 8'hF7);
        chk_out("R9 zero bit no clear", 1'b1, 3);
        wr_reg(2'd3, 8'h08);
        chk_out("R9 w1c clears", 1'b0, 0);
    endtask

    task automatic t_polarity();
        wr_reg(2'd2, 8'h30);
        wr_reg(2'd1, 8'h20);
        wr_reg(2'd0, 8'h10);
        cycles(3);
        chk_out("R5 active-low level", 1'b1, 4);
        @(negedge clk); lines[4] = 1'b1;
        cycles(3);
        chk_out("R5 active-low inactive", 1'b0, 0);
        wr_reg(2'd0, 8'h20);
        @(negedge clk); lines[5] = 1'b1;
        cycles(4);
        chk_out("R5 rising ignored", 1'b0, 0);
        @(negedge clk); lines[5] = 1'b0;
        cycles(4);
        chk_out("R5 falling captured", 1'b1, 5);
        wr_reg(2'd3, 8'h20);
        chk_out("R5 cleared", 1'b0, 0);
        @(negedge clk); lines[4] = 1'b0;
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd2, 8'h00);
    endtask

    task automatic t_masked_ack();
        wr_reg(2'd1, 8'h40);
        pulse(6);
        cycles(5);
        chk_out("R6 masked quiet", 1'b0, 0);
        wr_reg(2'd0, 8'h40);
        chk_out("R6 shown on unmask", 1'b1, 6);
        do_ack(6);
        chk_out("R10 ack clears", 1'b0, 0);
    endtask

    task automatic t_merge();
        pulse(6);
        cycles(2);
        pulse(6);
        cycles(2);
        pulse(6);
        cycles(4);
        chk_out("R7 merged pending", 1'b1, 6);
        wr_reg(2'd3, 8'h40);
        cycles(5);
        chk_out("R7 single clear", 1'b0, 0);
    endtask

    task automatic t_priority();
        wr_reg(2'd1, 8'h48);
        wr_reg(2'd0, 8'h4A);
        pulse(6);
        pulse(3);
        cycles(4);
        chk_out("R8 lowest edge wins", 1'b1, 3);
        @(negedge clk); lines[1] = 1'b1;
        cycles(3);
        chk_out("R8 level index 1 wins", 1'b1, 1);
        do_ack(1);
        cycles(1);
        chk_out("R10 ack on level no effect", 1'b1, 1);
        @(negedge clk); lines[1] = 1'b0;
        cycles(3);
        chk_out("R8 back to 3", 1'b1, 3);
        do_ack(3);
        chk_out("R8 next is 6", 1'b1, 6);
        do_ack(6);
        chk_out("R8 all served", 1'b0, 0);
    endtask

    task automatic t_clear_race();
        wr_reg(2'd1, 8'h80);
        wr_reg(2'd0, 8'h80);
        pulse(7);
        cycles(4);
        chk_out("R11 first pending", 1'b1, 7);
        @(negedge clk); lines[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        cycles(2);
        chk_out("R11 edge beats clear", 1'b1, 7);
        wr_reg(2'd3, 8'h80);
        chk_out("R11 later clear", 1'b0, 0);
        @(negedge clk); lines[7] = 1'b0;
        cycles(3);
    endtask

    task automatic t_inverted_mask();
        @(negedge clk); inv_lines[0] = 1'b1;
        cycles(4);
        check(inv_valid === 1'b0, "R12 inverted reset disables", int'(inv_valid), 0);
        @(negedge clk); inv_wr_en = 1'b1; inv_wr_data = 4'b1110;
        @(negedge clk); inv_wr_en = 1'b0;
        check(inv_valid === 1'b1, "R12 clear bit enables", int'(inv_valid), 1);
        check(inv_id === 2'd0, "R12 inverted id", int'(inv_id), 0);
        @(negedge clk); inv_wr_en = 1'b1; inv_wr_data = 4'b1111;
        @(negedge clk); inv_wr_en = 1'b0;
        check(inv_valid === 1'b0, "R12 set bit disables", int'(inv_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_latency_level();
        t_edge();
        t_polarity();
        t_masked_ack();
        t_merge();
        t_priority();
        t_clear_race();
        t_inverted_mask();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule